// File: doc/BRIEF.md
# Command FIFO Send Sequencer

This block is the host side of a command transfer into a TPM-style register window. Software first loads the command bytes into a local byte buffer through a simple write port, then pulses `start` with the command length. The sequencer then moves the whole command over a single-outstanding register-bus master port. That port carries three kinds of access: 32-bit status reads, 8-bit writes to the data port, and one final 32-bit status write.

Flow control comes from the device's status word. The engine first waits for the device to report that it can take a command. It then sends bytes in bursts that the burst-count field allows. After every burst it checks that the device still expects more data. The last byte is always sent on its own, and the engine must then see the expect flag drop. Only after that does it write the start-execution word. Every poll loop has a cycle budget. The outcome is reported with a one-cycle `done` pulse and a two-bit result code.

Top module: `cmd_send_seq`

## Requirements
- R1: No data-port write is issued until a status read has returned bit 6 (command ready) as 1. Until then the engine keeps re-reading status.
- R2: The burst count is status bits [23:8]. After any status read, the number of consecutive data-port writes never exceeds the count that read returned.
- R3: Each burst writes exactly min(burst, remaining − 1) bytes. A burst therefore never contains the final byte.
- R4: After each burst the engine re-reads status until bit 7 (valid) is 1. If bit 3 (expect) is then 0, it stops with result 2 (protocol error), and it issues no further data write and no go write.
- R5: A burst count of 0 makes the engine re-read status until the count is nonzero. If any poll loop stays unsatisfied for POLL_LIMIT clock cycles, the engine stops with result 1 (timeout) and does no more writes.
- R6: The final byte is written alone. This happens only after a valid status read showing exactly one byte remaining and a nonzero burst count.
- R7: After the final byte the engine waits for valid = 1. Expect must then read 0; otherwise the engine stops with result 2 and writes no go word.
- R8: On success the engine makes exactly one status write, of value 0x0000_0020 (bit 5 only). It then pulses `done` with result 0.
- R9: A `start` with length 0 or length above MAX_LEN gives `done` with result 3 in the very next cycle, and no bus access is made.
- R10: Data-port writes carry the buffer bytes in index order in `bus_wdata[7:0]`. A request keeps its fields stable until acknowledged, and only one request is outstanding at a time.
- R11: After reset the block is idle: `busy`, `done` and `bus_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Command buffer byte write enable |
| buf_waddr | input | AW | Command buffer write index |
| buf_wdata | input | 8 | Command buffer write byte |
| start | input | 1 | Begin sending; sampled only while idle |
| cmd_len | input | LEN_W | Command length in bytes |
| busy | output | 1 | A send is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 protocol error, 3 bad length |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_dport | output | 1 | 1 selects the 8-bit data port, 0 the 32-bit status register |
| bus_wdata | output | 32 | Write data; data-port bytes sit in bits [7:0] |
| bus_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| bus_rdata | input | 32 | Status read data |

## Verification
The bench models the device as a behavioural register responder. It checks every data write against the burst count of the preceding status read, using the rule min(burst, remaining − 1) and the one-byte rule for the final byte. It runs the engine under several patterns: a plain constant burst; a scripted mix of zero and small bursts, which separates re-polling from writing; a burst larger than the command, which shows the last byte is still held back; a one-byte command; and status reads with valid low, which must not release writes. Fault patterns separate the outcomes: expect dropping early (overflow), expect stuck high after the last byte, a device that never gets ready, and a burst count that stays zero. Each must give its own result code with no go write.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_PROTO   = 2'd2,
    RES_BADLEN  = 2'd3
  } res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RDY, S_LOOP, S_ZB, S_FETCH, S_WR, S_VAL, S_FIN, S_GO
  } st_e;

  localparam int STS_EXPECT = 3;
  localparam int STS_READY  = 6;
  localparam int STS_VALID  = 7;
  localparam int BURST_LSB  = 8;
  localparam int BURST_W    = 16;
  localparam logic [31:0] GO_WORD = 32'h0000_0020;
endpackage

// File: rtl/seq_cmd_buf.sv
module seq_cmd_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seq_bus_port.sv
module seq_bus_port (
  input  logic        clk,
  input  logic        rst,
  input  logic        issue,
  input  logic        iss_we,
  input  logic        iss_dport,
  input  logic [31:0] iss_wdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic        bus_dport,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  output logic        rsp
);
  assign rsp = bus_req && bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_dport <= 1'b0;
      bus_wdata <= '0;
    end else if (issue && !bus_req) begin
      bus_req   <= 1'b1;
      bus_we    <= iss_we;
      bus_dport <= iss_dport;
      bus_wdata <= iss_wdata;
    end else if (rsp) begin
      bus_req <= 1'b0;
    end
  end

  // R10: request and its fields held until acknowledged
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_dport) && $stable(bus_wdata)));
endmodule

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
  parameter int LIMIT = 1000000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt >= W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R5: a cleared budget is never already spent
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !expired);
endmodule

// File: rtl/cmd_send_seq.sv
module cmd_send_seq
  import seq_pkg::*;
#(
  parameter int MAX_LEN    = 256,
  parameter int POLL_LIMIT = 1000000,
  parameter int AW         = $clog2(MAX_LEN),
  parameter int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_waddr,
  input  logic [7:0]       buf_wdata,
  input  logic             start,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic             bus_req,
  output logic             bus_we,
  output logic             bus_dport,
  output logic [31:0]      bus_wdata,
  input  logic             bus_ack,
  input  logic [31:0]      bus_rdata
);
  st_e                st;
  logic [LEN_W-1:0]   len_q, sent;
  logic [BURST_W-1:0] burst_q;
  logic               last_q;
  logic               iss_q, iss_we_q, iss_dport_q;
  logic               tclr_q;
  logic               done_q;
  res_e               res_q;
  logic [7:0]         rd_byte;
  logic               rsp, expired;
  logic [31:0]        iss_wdata;
  logic [LEN_W-1:0]   rem;
  logic [BURST_W-1:0] stat_burst;

  assign rem        = len_q - sent;
  assign stat_burst = bus_rdata[BURST_LSB +: BURST_W];
  assign iss_wdata  = iss_dport_q ? {24'h0, rd_byte} : (iss_we_q ? GO_WORD : 32'h0);
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign result     = res_q;

  seq_cmd_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(sent[AW-1:0]), .rdata(rd_byte)
  );

  seq_bus_port u_port (
    .clk(clk), .rst(rst), .issue(iss_q), .iss_we(iss_we_q), .iss_dport(iss_dport_q),
    .iss_wdata(iss_wdata), .bus_req(bus_req), .bus_we(bus_we), .bus_dport(bus_dport),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .rsp(rsp)
  );

  seq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clr(tclr_q), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      len_q       <= '0;
      sent        <= '0;
      burst_q     <= '0;
      last_q      <= 1'b0;
      iss_q       <= 1'b0;
      iss_we_q    <= 1'b0;
      iss_dport_q <= 1'b0;
      tclr_q      <= 1'b0;
      done_q      <= 1'b0;
      res_q       <= RES_OK;
    end else begin
      iss_q  <= 1'b0;
      tclr_q <= 1'b0;
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (cmd_len == '0 || cmd_len > LEN_W'(MAX_LEN)) begin
            done_q <= 1'b1;
            res_q  <= RES_BADLEN;
          end else begin
            len_q <= cmd_len; sent <= '0; last_q <= 1'b0;
            st <= S_RDY; iss_q <= 1'b1; iss_we_q <= 1'b0; iss_dport_q <= 1'b0; tclr_q <= 1'b1;
          end
        end
        S_RDY: if (rsp) begin
          if (bus_rdata[STS_READY]) begin
            burst_q <= stat_burst; st <= S_LOOP;
          end else if (expired) begin
            st <= S_IDLE; done_q <= 1'b1; res_q <= RES_TIMEOUT;
          end else iss_q <= 1'b1;
        end
        S_LOOP: begin
          if (burst_q == '0) begin
            st <= S_ZB; iss_q <= 1'b1; iss_we_q <= 1'b0; iss_dport_q <= 1'b0; tclr_q <= 1'b1;
          end else if (rem > LEN_W'(1)) begin
            st <= S_FETCH;
          end else begin
            st <= S_VAL; iss_q <= 1'b1; iss_we_q <= 1'b0; iss_dport_q <= 1'b0; tclr_q <= 1'b1;
          end
        end
        S_ZB: if (rsp) begin
          if (stat_burst != '0) begin
            burst_q <= stat_burst; st <= S_LOOP;
          end else if (expired) begin
            st <= S_IDLE; done_q <= 1'b1; res_q <= RES_TIMEOUT;
          end else iss_q <= 1'b1;
        end
        S_FETCH: begin
          st <= S_WR; iss_q <= 1'b1; iss_we_q <= 1'b1; iss_dport_q <= 1'b1;
        end
        S_WR: if (rsp) begin
          sent    <= sent + 1'b1;
          burst_q <= burst_q - 1'b1;
          if (last_q) begin
            st <= S_FIN; iss_q <= 1'b1; iss_we_q <= 1'b0; iss_dport_q <= 1'b0; tclr_q <= 1'b1;
          end else if (burst_q != BURST_W'(1) && rem > LEN_W'(2)) begin
            st <= S_FETCH;
          end else begin
            st <= S_VAL; iss_q <= 1'b1; iss_we_q <= 1'b0; iss_dport_q <= 1'b0; tclr_q <= 1'b1;
          end
        end
        S_VAL: if (rsp) begin
          if (bus_rdata[STS_VALID]) begin
            if (!bus_rdata[STS_EXPECT]) begin
              st <= S_IDLE; done_q <= 1'b1; res_q <= RES_PROTO;
            end else begin
              burst_q <= stat_burst;
              if (rem == LEN_W'(1) && stat_burst != '0) begin
                last_q <= 1'b1; st <= S_FETCH;
              end else st <= S_LOOP;
            end
          end else if (expired) begin
            st <= S_IDLE; done_q <= 1'b1; res_q <= RES_TIMEOUT;
          end else iss_q <= 1'b1;
        end
        S_FIN: if (rsp) begin
          if (bus_rdata[STS_VALID]) begin
            if (bus_rdata[STS_EXPECT]) begin
              st <= S_IDLE; done_q <= 1'b1; res_q <= RES_PROTO;
            end else begin
              st <= S_GO; iss_q <= 1'b1; iss_we_q <= 1'b1; iss_dport_q <= 1'b0;
            end
          end else if (expired) begin
            st <= S_IDLE; done_q <= 1'b1; res_q <= RES_TIMEOUT;
          end else iss_q <= 1'b1;
        end
        S_GO: if (rsp) begin
          st <= S_IDLE; done_q <= 1'b1; res_q <= RES_OK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9: bad length answered in the next cycle
  a_r9_badlen: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && cmd_len == '0) |=> (done && result == RES_BADLEN && !bus_req));
  // R8: the only status write is the go word
  a_r8_go_word: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !bus_dport) |-> (bus_wdata == GO_WORD));
  // R3: byte index never passes the length
  a_r3_sent_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (sent <= len_q));
  // R6: the held-back write is the final byte
  a_r6_last_alone: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_dport && last_q) |-> (sent == len_q - 1'b1));
  // R11: nothing on the bus while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);
endmodule

// File: tb/cmd_send_seq_bench.sv
module cmd_send_seq_bench;
  localparam int MAX_LEN = 16;
  localparam int LIMIT   = 64;
  localparam int AW      = $clog2(MAX_LEN);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 0, rst = 1;
  logic buf_we = 0;
  logic [AW-1:0] buf_waddr = '0;
  logic [7:0] buf_wdata = '0;
  logic start = 0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic busy, done;
  logic [1:0] result;
  logic bus_req, bus_we, bus_dport;
  logic [31:0] bus_wdata;
  logic bus_ack = 0;
  logic [31:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  cmd_send_seq #(.MAX_LEN(MAX_LEN), .POLL_LIMIT(LIMIT)) u_cmd_send_seq (
    .clk(clk), .rst(rst), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .start(start), .cmd_len(cmd_len), .busy(busy), .done(done), .result(result),
    .bus_req(bus_req), .bus_we(bus_we), .bus_dport(bus_dport), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model state
  int dev_len, written, polls, ready_delay, ovf_at, vzero_left, def_burst;
  int exp_wr, wr_in_burst, go_cnt, traffic, lat_cnt;
  bit never_ready, stuck_expect, ready_seen;
  int bq[$];
  byte pat[MAX_LEN];
  bit held_valid;
  logic [33:0] held;

  function automatic int minv(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic handle();
    int b, rem;
    bit ex;
    logic [31:0] v;
    traffic++;
    if (bus_we && bus_dport) begin
      chk(ready_seen, "R1 write before ready", 0, 1);
      chk(written < dev_len, "R3 extra byte", written, dev_len - 1);
      if (written < dev_len)
        chk(bus_wdata[7:0] == pat[written], "R10 byte order", bus_wdata[7:0], pat[written]);
      written++;
      wr_in_burst++;
    end else if (bus_we) begin
      chk(bus_wdata == 32'h20, "R8 go word", bus_wdata, 32'h20);
      chk(written == dev_len, "R8 go before all bytes", written, dev_len);
      go_cnt++;
    end else begin
      chk(wr_in_burst == exp_wr, "R3 burst size (R2 R6)", wr_in_burst, exp_wr);
      wr_in_burst = 0;
      polls++;
      rem = dev_len - written;
      v = '0;
      if (!ready_seen) begin
        if (!never_ready && polls > ready_delay) begin
          ready_seen = 1;
          b = (bq.size() > 0) ? bq.pop_front() : def_burst;
          v[6] = 1; v[7] = 1; v[3] = 1; v[23:8] = b[15:0];
          exp_wr = minv(b, rem - 1);
        end else exp_wr = 0;
      end else if (vzero_left > 0 && written > 0) begin
        vzero_left--;
        exp_wr = 0;
      end else begin
        b = (bq.size() > 0) ? bq.pop_front() : def_burst;
        if (stuck_expect) ex = 1;
        else if (ovf_at >= 0 && written >= ovf_at) ex = 0;
        else ex = (written < dev_len);
        v[6] = 1; v[7] = 1; v[3] = ex; v[23:8] = b[15:0];
        if (rem == 0 || !ex) exp_wr = 0;
        else if (rem == 1) exp_wr = (b != 0) ? 1 : 0;
        else exp_wr = minv(b, rem - 1);
      end
      bus_rdata = v;
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 0; lat_cnt = 0; held_valid = 0;
    end else if (bus_ack) begin
      bus_ack = 0; lat_cnt = 0; held_valid = 0;
    end else if (bus_req) begin
      if (held_valid)
        chk(held == {bus_we, bus_dport, bus_wdata}, "R10 held fields", 0, 0);
      held = {bus_we, bus_dport, bus_wdata};
      held_valid = 1;
      if (lat_cnt >= (traffic % 3)) begin
        bus_ack = 1;
        handle();
      end else lat_cnt++;
    end
    if (!rst && !busy && bus_req) chk(0, "R11 request while idle", 1, 0);
  end

  task automatic setup(int rd, int db, int ov, bit nr, bit se, int vz);
    ready_delay = rd; def_burst = db; ovf_at = ov; never_ready = nr;
    stuck_expect = se; vzero_left = vz;
  endtask

  task automatic send(int len, int exp_res, int exp_written, string tag);
    int waited;
    for (int i = 0; i < MAX_LEN; i++) begin
      @(negedge clk);
      pat[i] = byte'(8'h3C + i * 13 + len);
      buf_we = 1; buf_waddr = AW'(i); buf_wdata = pat[i];
    end
    @(negedge clk);
    buf_we = 0;
    dev_len = len; written = 0; polls = 0; ready_seen = 0;
    exp_wr = 0; wr_in_burst = 0; go_cnt = 0; traffic = 0;
    start = 1; cmd_len = LEN_W'(len);
    @(negedge clk);
    start = 0;
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk(done, {tag, " done seen"}, done, 1);
    chk(result == 2'(exp_res), {tag, " result"}, result, exp_res);
    chk(written == exp_written, {tag, " bytes written"}, written, exp_written);
    chk(go_cnt == ((exp_res == 0) ? 1 : 0), {tag, " go writes"}, go_cnt, (exp_res == 0) ? 1 : 0);
    if (exp_res == 3) begin
      chk(waited == 0, "R9 answered next cycle", waited, 0);
      chk(traffic == 0, "R9 no bus access", traffic, 0);
    end
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk(!busy && !bus_req, {tag, " quiet after done"}, busy, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req, "R11 reset state", busy, 0);
    rst = 0;
    @(negedge clk);

    setup(0, 4, -1, 0, 0, 0); bq = {};
    send(0, 3, 0, "R9 zero length");
    send(MAX_LEN + 1, 3, 0, "R9 long length");

    setup(3, 4, -1, 0, 0, 0); bq = {};
    send(10, 0, 10, "R1 R8 plain bursts");

    setup(0, 4, -1, 0, 0, 0); bq = {0, 0, 3, 1, 0, 2};
    send(10, 0, 10, "R5 zero burst mix");

    setup(1, 100, -1, 0, 0, 0); bq = {};
    send(6, 0, 6, "R6 large burst");

    setup(0, 5, -1, 0, 0, 0); bq = {};
    send(1, 0, 1, "R6 single byte");

    setup(0, 3, -1, 0, 0, 2); bq = {};
    send(8, 0, 8, "R4 valid low polls");

    setup(0, 4, 3, 0, 0, 0); bq = {};
    send(10, 2, 4, "R4 overflow");

    setup(0, 8, -1, 0, 1, 0); bq = {};
    send(5, 2, 5, "R7 expect stuck");

    setup(0, 4, -1, 1, 0, 0); bq = {};
    send(7, 1, 0, "R5 never ready");

    setup(0, 0, -1, 0, 0, 0); bq = {};
    send(7, 1, 0, "R5 burst stays zero");

    setup(2, 2, -1, 0, 0, 0); bq = {};
    send(MAX_LEN, 0, MAX_LEN, "R2 R10 full length");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule